// File: doc/BRIEF.md
# Split-DAC SAR Conversion Controller

This block is the digital sequencer of a 10-bit successive-approximation pixel ADC. A start request begins a conversion. The controller then works out the result one bit at a time, starting with the most significant bit. It presents each trial code to a hybrid DAC. The upper four bits drive a capacitor-array section and the lower six bits drive a resistor-ladder section. A comparator returns one decision bit per trial. The controller uses that bit to keep or clear the bit under test.

When the last bit has been decided, the controller loads the code into a result register and pulses a done strobe for one cycle. It then returns to idle with every DAC code line at zero. A conversion-clock enable is high only while a conversion is in progress. It gates the comparator and DAC clocking, which normally runs at 1 MHz, so that clock is off while the pixel is idle.

The result leaves as a one-cycle valid pulse with data. There is no ready input and no back-pressure. The consumer must capture the result in the cycle the strobe is high, or read it later from the held result port before the next strobe.

Top module: `sar_split_ctrl`

## Requirements
- R1: On a clock edge where `start_i` is 1 and the controller is idle, a conversion begins. After that edge `cap_code_o` is 4'b1000, `res_code_o` is 0 and `conv_clk_en_o` is 1.
- R2: On each of the next 10 edges, one trial bit is decided, from bit 9 down to bit 0. The bit under test is kept if `cmp_i` is 1, which means the analog input is at or above the DAC level; otherwise it is cleared. The next lower bit is then set for its own trial.
- R3: The trial code is split across the two DAC ports. `cap_code_o` carries trial bits 9..6 (bit 9 in its MSB). `res_code_o` carries trial bits 5..0.
- R4: While any of the six resistor bits is under trial, `cap_code_o` does not change.
- R5: The edge after bit 0 is decided, `result_o` takes the final code and `done_o` goes to 1. That is the 11th edge after the start edge. With an ideal comparator, the result equals the input level, for levels 0 to 1023.
- R6: `done_o` is high for exactly one cycle per conversion.
- R7: Whenever `conv_clk_en_o` is 0, both DAC code ports are zero.
- R8: A start request during a conversion has no effect. This covers the 10 trial cycles and the load cycle. No conversion is restarted and no extra done pulse appears.
- R9: After reset, all code ports, `result_o`, `done_o` and `conv_clk_en_o` are zero.
- R10: `result_o` changes only together with a done pulse and holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above DAC level |
| cap_code_o | output | 4 | Capacitor-array DAC code (trial bits 9..6) |
| res_code_o | output | 6 | Resistor-ladder DAC code (trial bits 5..0) |
| result_o | output | 10 | Last completed conversion result |
| done_o | output | 1 | One-cycle strobe marking a new valid result |
| conv_clk_en_o | output | 1 | Conversion clock enable, high during a conversion |

## Verification
The assertions assume the following about the inputs:
- `cmp_i` is a settled, synchronous function of the DAC code presented in the same cycle.
- `start_i` is a synchronous level.

The bench meets both assumptions:
- Its comparator model computes `cmp_i` combinationally from the two DAC code ports and a fixed input level.
- It drives the input level and `start_i` only on falling edges.
- It changes the input level only while the controller is idle.

Start pulses are deliberately placed inside the trial phase and the load phase, and one request is held high across back-to-back conversions. This exercises the ignore rule without breaking these assumptions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_LOAD  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output sar_state_e       state_o,
  output logic [NBITS-1:0] ptr_o,
  output logic             launch_o
);
  localparam logic [NBITS-1:0] PTR_TOP = {1'b1, {(NBITS-1){1'b0}}};

  sar_state_e       state_q;
  logic [NBITS-1:0] ptr_q;

  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign state_o  = state_q;
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_TRIAL;
            ptr_q   <= PTR_TOP;
          end
        end
        ST_TRIAL: begin
          if (ptr_q[0]) begin
            state_q <= ST_LOAD;
            ptr_q   <= '0;
          end else begin
            ptr_q <= ptr_q >> 1;
          end
        end
        ST_LOAD: begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
          ptr_q   <= '0;
        end
      endcase
    end
  end

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q)); // R2
  AST_TRIAL_HAS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIAL) |-> (ptr_q != '0)); // R2
  AST_TRIAL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIAL && !ptr_q[0]) |=> (state_q == ST_TRIAL && !ptr_q[NBITS-1])); // R8
  AST_LOAD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sar_state_e       state_i,
  input  logic [NBITS-1:0] ptr_i,
  input  logic             launch_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] code_o
);
  localparam logic [NBITS-1:0] CODE_TOP = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] code_q;
  logic [NBITS-1:0] set_next;

  for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
    if (gi == NBITS - 1) begin : g_top
      assign set_next[gi] = 1'b0;
    end else begin : g_low
      assign set_next[gi] = ptr_i[gi+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[gi] <= 1'b0;
      end else begin
        unique case (state_i)
          ST_IDLE: begin
            if (launch_i) code_q[gi] <= (gi == NBITS - 1);
          end
          ST_TRIAL: begin
            if (ptr_i[gi])          code_q[gi] <= cmp_i;
            else if (set_next[gi])  code_q[gi] <= 1'b1;
          end
          ST_LOAD: begin
            code_q[gi] <= 1'b0;
          end
          default: code_q[gi] <= 1'b0;
        endcase
      end
    end
  end

  assign code_o = code_q;

  AST_LAUNCH_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (code_q == CODE_TOP)); // R1
  AST_DECIDED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_TRIAL && ptr_i[0]) |=> (code_q[0] == $past(cmp_i))); // R2
endmodule

// File: rtl/sar_dac_split.sv
module sar_dac_split #(
  parameter int CAP_BITS = 4,
  parameter int RES_BITS = 6,
  localparam int NBITS   = CAP_BITS + RES_BITS
) (
  input  logic [NBITS-1:0]    code_i,
  output logic [CAP_BITS-1:0] cap_o,
  output logic [RES_BITS-1:0] res_o
);
  for (genvar gc = 0; gc < CAP_BITS; gc++) begin : g_cap
    assign cap_o[gc] = code_i[RES_BITS + gc];
  end
  for (genvar gr = 0; gr < RES_BITS; gr++) begin : g_res
    assign res_o[gr] = code_i[gr];
  end
endmodule

// File: rtl/sar_split_ctrl.sv
module sar_split_ctrl
  import sar_pkg::*;
#(
  parameter int CAP_BITS = 4,
  parameter int RES_BITS = 6,
  localparam int NBITS   = CAP_BITS + RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [CAP_BITS-1:0] cap_code_o,
  output logic [RES_BITS-1:0] res_code_o,
  output logic [NBITS-1:0]    result_o,
  output logic                done_o,
  output logic                conv_clk_en_o
);
  sar_state_e       state;
  logic [NBITS-1:0] ptr;
  logic             launch;
  logic [NBITS-1:0] code;
  logic [NBITS-1:0] result_q;
  logic             done_q;

  sar_seq #(.NBITS(NBITS)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .state_o  (state),
    .ptr_o    (ptr),
    .launch_o (launch)
  );

  sar_trial_reg #(.NBITS(NBITS)) i_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .ptr_i    (ptr),
    .launch_i (launch),
    .cmp_i    (cmp_i),
    .code_o   (code)
  );

  sar_dac_split #(.CAP_BITS(CAP_BITS), .RES_BITS(RES_BITS)) i_split (
    .code_i (code),
    .cap_o  (cap_code_o),
    .res_o  (res_code_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state == ST_LOAD);
      if (state == ST_LOAD) result_q <= code;
    end
  end

  assign result_o      = result_q;
  assign done_o        = done_q;
  assign conv_clk_en_o = (state != ST_IDLE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state == ST_LOAD)); // R5
  AST_IDLE_CODES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_clk_en_o |-> (cap_code_o == '0 && res_code_o == '0)); // R7
  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIAL && ptr[RES_BITS-1:0] != '0) |=> $stable(cap_code_o)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R10
endmodule

// File: tb/test_sar_split_ctrl.sv
module test_sar_split_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cmp_i;
  logic [3:0] cap_code_o;
  logic [5:0] res_code_o;
  logic [9:0] result_o;
  logic       done_o;
  logic       conv_clk_en_o;

  int vin = 0;
  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model state
  int m_state = 0;  // 0 idle, 1 trial, 2 load
  int m_bit = 0;
  int m_code = 0;
  int m_res = 0;
  int m_done = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Behavioural comparator: 1 when the input is at or above the DAC level
  assign cmp_i = (vin >= int'({cap_code_o, res_code_o}));

  sar_split_ctrl i_sar_split_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .cmp_i         (cmp_i),
    .cap_code_o    (cap_code_o),
    .res_code_o    (res_code_o),
    .result_o      (result_o),
    .done_o        (done_o),
    .conv_clk_en_o (conv_clk_en_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Reference model, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_bit = 0; m_code = 0; m_res = 0; m_done = 0;
    end else begin
      case (m_state)
        0: begin
          m_done = 0;
          if (start_i) begin
            m_state = 1; m_bit = 9; m_code = 512;
          end
        end
        1: begin
          m_done = 0;
          if (!(vin >= m_code)) m_code = m_code - (1 << m_bit);
          if (m_bit == 0) m_state = 2;
          else begin
            m_bit = m_bit - 1;
            m_code = m_code + (1 << m_bit);
          end
        end
        default: begin
          m_res = m_code; m_done = 1; m_code = 0; m_state = 0;
        end
      endcase
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(cap_code_o) == (m_code >> 6), "R3 cap code", cap_code_o, m_code >> 6);
      check(int'(res_code_o) == (m_code & 63), "R2 res code", res_code_o, m_code & 63);
      check(int'(result_o) == m_res, "R10 result", result_o, m_res);
      check(int'(done_o) == m_done, "R6 done", done_o, m_done);
      check(int'(conv_clk_en_o) == (m_state != 0 ? 1 : 0), "R7 clk enable",
            conv_clk_en_o, m_state != 0 ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 150000);
      finish_run();
    end
  end

  // One conversion, optionally with stray start pulses inside it
  task automatic convert(input int v, input bit stray);
    int cap_mid;
    @(negedge clk);
    vin = v;
    start_i = 1'b1;
    @(negedge clk);  // n1
    start_i = 1'b0;
    check(cap_code_o == 4'b1000 && res_code_o == 6'd0, "R1 first trial",
          {cap_code_o, res_code_o}, 512);
    check(conv_clk_en_o == 1'b1, "R1 enable up", conv_clk_en_o, 1);
    repeat (3) @(negedge clk);  // n4
    if (stray) start_i = 1'b1;   // R8 stray start during trials
    @(negedge clk);             // n5
    start_i = 1'b0;
    cap_mid = cap_code_o;
    repeat (6) @(negedge clk);  // n11: load cycle
    check(int'(cap_code_o) == cap_mid, "R4 cap frozen", cap_code_o, cap_mid);
    check(int'(cap_code_o) == (v >> 6), "R4 cap final", cap_code_o, v >> 6);
    if (stray) start_i = 1'b1;   // R8 stray start during load
    @(negedge clk);             // n12
    start_i = 1'b0;
    check(done_o == 1'b1, "R5 done timing", done_o, 1);
    check(int'(result_o) == v, "R5 result value", result_o, v);
    @(negedge clk);             // n13
    check(done_o == 1'b0, "R8 no extra done", done_o, 0);
    check(conv_clk_en_o == 1'b0, "R8 no restart", conv_clk_en_o, 0);
    check(cap_code_o == 4'd0 && res_code_o == 6'd0, "R7 idle zero",
          {cap_code_o, res_code_o}, 0);
  endtask

  initial begin
    int lfsr = 10'h2a5;
    repeat (3) @(negedge clk);
    check(cap_code_o == 4'd0 && res_code_o == 6'd0, "R9 reset codes",
          {cap_code_o, res_code_o}, 0);
    check(result_o == 10'd0 && done_o == 1'b0, "R9 reset result",
          {done_o, result_o}, 0);
    check(conv_clk_en_o == 1'b0, "R9 reset enable", conv_clk_en_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    convert(0, 0);
    convert(1023, 0);
    convert(512, 1);
    convert(511, 0);
    convert(341, 1);
    convert(682, 0);
    convert(1, 1);
    convert(64, 0);
    convert(63, 1);
    for (int k = 0; k < 12; k++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 9) ^ (lfsr >> 6)) & 1)) & 1023;
      convert(lfsr, k[0]);
    end

    // R10: result holds while idle for a while
    repeat (20) @(negedge clk);
    check(int'(result_o) == m_res, "R10 hold idle", result_o, m_res);

    // Back-to-back: start held high across two conversions
    @(negedge clk);
    vin = 777;
    start_i = 1'b1;
    repeat (26) @(negedge clk);
    start_i = 1'b0;
    repeat (16) @(negedge clk);
    check(int'(result_o) == 777, "R5 back-to-back result", result_o, 777);

    // Reset in the middle of a conversion
    @(negedge clk);
    vin = 300;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(conv_clk_en_o == 1'b0 && result_o == 10'd0, "R9 mid reset",
          {conv_clk_en_o, result_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule